// File: doc/BRIEF.md
# Duplex Checker with Triple-Vote Escalation

This block watches three copies of one functional unit. At any time two copies are in service and the third is either a cold spare or out for repair. In normal operation the two in-service outputs are compared whenever both are strobed valid. A matching pair is forwarded one cycle later.

A disagreement does not yet show which side is at fault. The block therefore drops that result and calls in the spare. On the next input presented to all three copies it takes a 2-of-3 vote. It forwards the majority value and names the outvoted slot. That slot is retired to repair, and if the spare was not the culprit the spare takes its place. Pair checking then resumes.

A separate input tells the block that the repair logic has finished with the retired slot, which then becomes the new spare. The role table is protected by a checksum held alongside it, so that damage to the checker's own bookkeeping raises a distinct flag.

Top module: `dup_tmr_guard`

## Requirements
- R1: After reset, slots 0 and 1 hold role code 01 (in service) and slot 2 holds role code 10 (spare); out_vld, rep_req, unresolved, fault_id and self_err are all zero. Role code 11 means under repair. Slot i's role is roles[2i+1:2i].
- R2: In pair mode, when both in-service slots are valid and their data are equal, out_vld is 1 in the next cycle and out_data carries that value.
- R3: In pair mode, a disagreement between the two valid in-service slots while the third slot is a spare gives no output for that input and switches to vote mode. Vote mode then waits, with no output, until all three valid strobes are high together.
- R4: In vote mode with exactly two slots agreeing, in the next cycle out_vld is 1 with the majority value, rep_req pulses for one cycle, and fault_id equals the outvoted slot index plus one. The outvoted slot becomes role 11. The spare becomes role 01 unless it is itself the outvoted slot. The block returns to pair mode.
- R5: In vote mode with all three slots equal, the value is forwarded, no repair request is raised, all roles keep their values and the block returns to pair mode.
- R6: In vote mode with all three slots different, unresolved pulses for one cycle, no output is produced, all roles keep their values and the block returns to pair mode.
- R7: In pair mode, a disagreement while the third slot is under repair raises unresolved for one cycle, produces no output and stays in pair mode.
- R8: A rep_done pulse in pair mode turns a slot in role 11 into role 10 in the next cycle. This happens even in the same cycle as an R7 disagreement, which is still judged on the roles held before the edge. With no slot in repair, rep_done has no effect.
- R9: self_err is raised when the role table no longer matches its stored checksum. During legal operation it stays 0.
- R10: In pair mode, the data and strobe of the third slot have no influence. If either in-service strobe is low, nothing is compared, no output appears and the mode does not change.
- R11: Exactly two slots hold role 01 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_vld | input | 3 | Valid strobe of each slot, bit i for slot i |
| u_data | input | 3*DW | Slot outputs, slot i in bits [i*DW +: DW] |
| rep_done | input | 1 | Repair of the retired slot has completed |
| out_vld | output | 1 | Checked result valid |
| out_data | output | DW | Checked or voted result |
| fault_id | output | 2 | Outvoted slot plus one on a repair request, else 0 |
| rep_req | output | 1 | One-cycle request to repair the slot named by fault_id |
| unresolved | output | 1 | One-cycle flag: no majority, or disagreement with no spare |
| self_err | output | 1 | Role table and stored checksum disagree |
| roles | output | 6 | Role code of each slot, two bits per slot |

## Verification
Two events can land on the same clock edge. One is a pair disagreement found while the third slot is still under repair. The other is the rep_done pulse that returns that slot to spare duty. The bench drives both in one cycle. It expects unresolved to be raised, because the decision uses the roles held before the edge, and it expects the repaired slot to read as spare afterwards. A following disagreement must then escalate to a vote. A reference model is advanced with every input and compared on each clock.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int NSLOT = 3;
  localparam logic [1:0] ROLE_ACT = 2'b01;
  localparam logic [1:0] ROLE_SBY = 2'b10;
  localparam logic [1:0] ROLE_REP = 2'b11;
  localparam logic [5:0] ROLES_RST = {ROLE_SBY, ROLE_ACT, ROLE_ACT};

  typedef enum logic {MODE_PAIR = 1'b0, MODE_VOTE = 1'b1} mode_t;

  // Weighted sum of role codes: a swap or a corrupted code changes it.
  function automatic logic [3:0] role_sum(input logic [5:0] r);
    logic [3:0] s;
    s = {2'b00, r[1:0]} + {1'b0, r[3:2], 1'b0} + {2'b00, r[5:4]} + {1'b0, r[5:4], 1'b0};
    return s;
  endfunction
endpackage

// File: rtl/dtg_pair_cmp.sv
module dtg_pair_cmp #(
  parameter int DW = 8
) (
  input  logic [3*DW-1:0] data,
  output logic [2:0]      eq
);
  // eq[0]: slots 0/1, eq[1]: slots 0/2, eq[2]: slots 1/2
  for (genvar k = 0; k < 3; k++) begin : g_pair
    localparam int SA = (k == 2) ? 1 : 0;
    localparam int SB = (k == 0) ? 1 : 2;
    assign eq[k] = (data[SA*DW +: DW] == data[SB*DW +: DW]);
  end
endmodule

// File: rtl/dtg_role_table.sv
module dtg_role_table
  import dtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] wr_roles,
  output logic [5:0] roles,
  output logic       self_err
);
  logic [5:0] roles_q, roles_n;
  logic [3:0] ref_q, ref_n;
  logic       err_q, err_n;
  logic [2:0] act;

  always_comb begin
    roles_n = roles_q;
    ref_n   = ref_q;
    if (wr_en) begin
      roles_n = wr_roles;
      ref_n   = role_sum(wr_roles);
    end
    err_n = (role_sum(roles_q) != ref_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roles_q <= ROLES_RST;
      ref_q   <= role_sum(ROLES_RST);
      err_q   <= 1'b0;
    end else begin
      roles_q <= roles_n;
      ref_q   <= ref_n;
      err_q   <= err_n;
    end
  end

  assign roles    = roles_q;
  assign self_err = err_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_act
    assign act[i] = (roles_q[2*i +: 2] == ROLE_ACT);
  end

  a_r11_two_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) == 2);
  a_r9_no_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (roles_q[1:0] != 2'b00) && (roles_q[3:2] != 2'b00) && (roles_q[5:4] != 2'b00));
endmodule

// File: rtl/dup_tmr_guard.sv
module dup_tmr_guard
  import dtg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      u_vld,
  input  logic [3*DW-1:0] u_data,
  input  logic            rep_done,
  output logic            out_vld,
  output logic [DW-1:0]   out_data,
  output logic [1:0]      fault_id,
  output logic            rep_req,
  output logic            unresolved,
  output logic            self_err,
  output logic [5:0]      roles
);
  mode_t         mode_q, mode_n;
  logic          vld_q, vld_n, rq_q, rq_n, un_q, un_n;
  logic [DW-1:0] data_q, data_n;
  logic [1:0]    fid_q, fid_n;
  logic          wr_en;
  logic [5:0]    wr_roles;
  logic [2:0]    eq;
  logic [DW-1:0] d [0:2];
  logic [2:0]    act;
  logic [1:0]    spare, a0, a1, odd;
  logic [1:0]    spare_role;
  logic          pair_fire, pair_eq;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign d[i]   = u_data[i*DW +: DW];
    assign act[i] = (roles[2*i +: 2] == ROLE_ACT);
  end

  dtg_pair_cmp #(.DW(DW)) u_cmp (.data(u_data), .eq(eq));

  dtg_role_table u_roles (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_roles(wr_roles),
    .roles(roles), .self_err(self_err)
  );

  assign spare      = act[0] ? (act[1] ? 2'd2 : 2'd1) : 2'd0;
  assign a0         = (spare == 2'd0) ? 2'd1 : 2'd0;
  assign a1         = (spare == 2'd2) ? 2'd1 : 2'd2;
  assign spare_role = roles[{spare, 1'b0} +: 2];
  assign pair_fire  = u_vld[a0] & u_vld[a1];
  assign pair_eq    = eq[2'd2 - spare];
  assign odd        = eq[2] ? 2'd0 : (eq[1] ? 2'd1 : 2'd2);

  always_comb begin
    mode_n   = mode_q;
    vld_n    = 1'b0;
    data_n   = data_q;
    fid_n    = 2'd0;
    rq_n     = 1'b0;
    un_n     = 1'b0;
    wr_en    = 1'b0;
    wr_roles = roles;
    if (mode_q == MODE_PAIR) begin
      if (pair_fire) begin
        if (pair_eq) begin
          vld_n  = 1'b1;
          data_n = d[a0];
        end else if (spare_role == ROLE_SBY) begin
          mode_n = MODE_VOTE;
        end else begin
          un_n = 1'b1;
        end
      end
      if (rep_done && (spare_role == ROLE_REP)) begin
        wr_en = 1'b1;
        wr_roles[{spare, 1'b0} +: 2] = ROLE_SBY;
      end
    end else if (&u_vld) begin
      mode_n = MODE_PAIR;
      if (eq[0] && eq[1]) begin
        vld_n  = 1'b1;
        data_n = d[0];
      end else if (|eq) begin
        vld_n  = 1'b1;
        data_n = eq[2] ? d[1] : d[0];
        fid_n  = odd + 2'd1;
        rq_n   = 1'b1;
        wr_en  = 1'b1;
        wr_roles[{odd, 1'b0} +: 2] = ROLE_REP;
        if (odd != spare) wr_roles[{spare, 1'b0} +: 2] = ROLE_ACT;
      end else begin
        un_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PAIR;
      vld_q  <= 1'b0;
      fid_q  <= 2'd0;
      rq_q   <= 1'b0;
      un_q   <= 1'b0;
    end else begin
      mode_q <= mode_n;
      vld_q  <= vld_n;
      fid_q  <= fid_n;
      rq_q   <= rq_n;
      un_q   <= un_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (vld_n) data_q <= data_n;
  end

  assign out_vld    = vld_q;
  assign out_data   = data_q;
  assign fault_id   = fid_q;
  assign rep_req    = rq_q;
  assign unresolved = un_q;

  a_r2_agree_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PAIR && pair_fire && pair_eq) |=> out_vld);
  a_r3_mismatch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PAIR && pair_fire && !pair_eq) |=> !out_vld);
  a_r4_request_names_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rep_req |-> (fault_id != 2'd0) && out_vld);
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rep_req && unresolved) && !(unresolved && out_vld));
  a_r5_vote_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_VOTE && (&u_vld)) |=> (mode_q == MODE_PAIR));
endmodule

// File: tb/dup_tmr_guard_bench.sv
`timescale 1ns/1ps
module dup_tmr_guard_bench;
  localparam int DW = 8;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [2:0]    u_vld;
  logic [3*DW-1:0] u_data;
  logic          rep_done;
  logic          out_vld, rep_req, unresolved, self_err;
  logic [DW-1:0] out_data;
  logic [1:0]    fault_id;
  logic [5:0]    roles;

  dup_tmr_guard #(.DW(DW)) u_dup_tmr_guard (
    .clk(clk), .rst_n(rst_n), .u_vld(u_vld), .u_data(u_data), .rep_done(rep_done),
    .out_vld(out_vld), .out_data(out_data), .fault_id(fault_id), .rep_req(rep_req),
    .unresolved(unresolved), .self_err(self_err), .roles(roles)
  );

  int n_chk = 0;
  int n_bad = 0;
  int mr[3];
  bit mvote;
  bit e_vld, e_rq, e_un;
  int e_data, e_fid;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int role_vec();
    return mr[0] | (mr[1] << 2) | (mr[2] << 4);
  endfunction

  task automatic model(logic [2:0] v, int dv[3], logic rd);
    int sp, p, q, n_act;
    sp = 0;
    for (int i = 0; i < 3; i++) if (mr[i] != 1) sp = i;
    p = (sp == 0) ? 1 : 0;
    q = (sp == 2) ? 1 : 2;
    e_vld = 0; e_rq = 0; e_un = 0; e_fid = 0;
    if (!mvote) begin
      if (v[p] && v[q]) begin
        if (dv[p] == dv[q]) begin e_vld = 1; e_data = dv[p]; end
        else if (mr[sp] == 2) mvote = 1;
        else e_un = 1;
      end
      if (rd && mr[sp] == 3) mr[sp] = 2;
    end else if (v == 3'b111) begin
      mvote = 0;
      if (dv[0] == dv[1] && dv[1] == dv[2]) begin
        e_vld = 1; e_data = dv[0];
      end else begin
        int culprit = -1;
        for (int i = 0; i < 3; i++) begin
          int j = (i + 1) % 3;
          int k = (i + 2) % 3;
          if (dv[j] == dv[k] && dv[i] != dv[j]) begin culprit = i; e_data = dv[j]; end
        end
        if (culprit >= 0) begin
          e_vld = 1; e_rq = 1; e_fid = culprit + 1;
          mr[culprit] = 3;
          if (culprit != sp) mr[sp] = 1;
        end else e_un = 1;
      end
    end
    n_act = 0;
    for (int i = 0; i < 3; i++) if (mr[i] == 1) n_act++;
    if (n_act != 2) $display("model note: active count %0d", n_act);
  endtask

  task automatic step(string tag, logic [2:0] v, int x0, int x1, int x2, logic rd);
    int dv[3];
    int n_act;
    dv[0] = x0; dv[1] = x1; dv[2] = x2;
    u_vld = v;
    u_data = {x2[7:0], x1[7:0], x0[7:0]};
    rep_done = rd;
    model(v, dv, rd);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "out_vld", int'(out_vld), int'(e_vld));
    if (e_vld) chk(tag, "out_data", int'(out_data), e_data);
    chk(tag, "rep_req", int'(rep_req), int'(e_rq));
    chk(tag, "fault_id", int'(fault_id), e_fid);
    chk(tag, "unresolved", int'(unresolved), int'(e_un));
    chk(tag, "roles", int'(roles), role_vec());
    chk("R9", "self_err", int'(self_err), 0);
    n_act = 0;
    for (int i = 0; i < 3; i++) if (roles[2*i +: 2] == 2'b01) n_act++;
    chk("R11", "in_service_count", n_act, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; u_vld = '0; u_data = '0; rep_done = 1'b0;
    mr[0] = 1; mr[1] = 1; mr[2] = 2; mvote = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "roles", int'(roles), 6'b10_01_01);
    chk("R1", "out_vld", int'(out_vld), 0);
    chk("R1", "rep_req", int'(rep_req), 0);
    chk("R1", "unresolved", int'(unresolved), 0);
    chk("R1", "fault_id", int'(fault_id), 0);
    chk("R1", "self_err", int'(self_err), 0);

    // R2 and R10: pair agreement, spare data ignored
    step("R2", 3'b111, 5, 5, 9, 0);
    step("R2", 3'b011, 8'hA0, 8'hA0, 0, 0);
    step("R10", 3'b101, 7, 8, 1, 0);
    step("R10", 3'b011, 3, 3, 77, 0);
    // R3: mismatch, then vote waits for all three strobes
    step("R3", 3'b111, 1, 2, 1, 0);
    step("R3", 3'b011, 1, 2, 1, 0);
    // R4: slot 1 outvoted, spare takes its place
    step("R4", 3'b111, 4, 6, 4, 0);
    // R7 with R8 in the same cycle: no spare yet, repair completes
    step("R7", 3'b101, 1, 0, 2, 1);
    // R8: rep_done with no slot in repair is ignored
    step("R8", 3'b000, 0, 0, 0, 1);
    // R5: escalate, all three equal
    step("R3", 3'b101, 9, 0, 8, 0);
    step("R5", 3'b111, 7, 7, 7, 0);
    // R6: escalate, all three differ
    step("R3", 3'b101, 1, 0, 2, 0);
    step("R6", 3'b111, 1, 2, 3, 0);
    // R4: spare itself outvoted
    step("R3", 3'b101, 5, 0, 6, 0);
    step("R4", 3'b111, 5, 9, 5, 0);
    // R8: repaired spare returns, then escalation works again
    step("R8", 3'b000, 0, 0, 0, 1);
    step("R2", 3'b101, 12, 0, 12, 0);
    step("R3", 3'b101, 12, 0, 13, 0);
    step("R4", 3'b111, 14, 13, 13, 0);
    step("R2", 3'b110, 0, 21, 21, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule